// File: doc/BRIEF.md
# Channel Completion Status Queue

A storage host controller with four channels needs one place where finished commands are reported. Each channel posts a record when its command ends. The record holds the channel number, a 6-bit host status code and the 8-bit status byte returned by the drive. A round-robin arbiter admits at most one post per cycle into a shared first-in first-out store.

Software drains the store through two 32-bit reads per record. It reads the low word first, which gives the drive status. It then reads the high word, which gives the channel tag, the host code, a valid flag and an empty flag, and which also retires the record. Software keeps reading until the empty flag is set.

A single interrupt line stays high while records wait and the global enable is set. By convention, host code 0 means the command packet succeeded and code 3 means the drive reported an error. Software interprets the code; the queue stores it unchanged.

Top module: `cmpl_status_queue`

## Requirements
- R1: After reset the queue is empty and the interrupt enable is clear. A high-word read returns 32'h8000_0000, a low-word read returns 0, and `irq` is 0.
- R2: High word (`rd_sel`=1) of a held record: bit 31 = 0 (empty), bit 30 = 1 (valid), bits 9:8 = channel number, bits 5:0 = host status code. All other bits are 0.
- R3: Low word (`rd_sel`=0): bits 23:16 = drive status byte of the head record, and all other bits are 0. A low-word read does not retire the record.
- R4: A high-word read retires the head record. Records leave in the order they were accepted.
- R5: A high-word read while the queue is empty returns 32'h8000_0000 (empty=1, valid=0) and changes nothing. A record posted afterwards is the next one read.
- R6: At most one `post_ready` bit is high in a cycle, and only for a channel whose `post_valid` is high. Priority rotates: the search starts at the channel after the one last granted and wraps after channel NCH-1. After reset the search starts at channel 0.
- R7: A channel that is not granted keeps its request. It is accepted in a later cycle, and no record is lost.
- R8: While DEPTH records are held, every `post_ready` bit is 0. Posting resumes in the cycle after a record is retired.
- R9: `irq` is 1 exactly when at least one record is held and the interrupt enable is set. It rises in the cycle after the accepting edge.
- R10: A write of a nonzero byte to the interrupt-control register sets the enable, and a write of zero clears it. The change shows on `irq` after the writing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low global reset |
| post_valid | input | NCH | Per-channel post request |
| post_hstat | input | 6*NCH | Host status code per channel, channel c at bits 6c+5:6c |
| post_dstat | input | 8*NCH | Drive status byte per channel, channel c at bits 8c+7:8c |
| post_ready | output | NCH | Grant: the post of that channel is taken at this edge |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects the low word, 1 selects the high word (retiring) |
| rd_data | output | 32 | Read data for the selected word |
| cfg_we | input | 1 | Write strobe for the interrupt-control byte |
| cfg_wdata | input | 8 | Interrupt-control byte |
| irq | output | 1 | Interrupt request |

## Verification
A wrong occupancy count is the most damaging internal fault. It appears at the ports within one read or post: the empty flag contradicts the valid flag, a stale record comes back, or `post_ready` stays low below capacity or high at capacity. A corrupt arbiter pointer shows in the first cycle of contention, as the wrong `post_ready` bit. A wrong enable state shows on `irq` in the cycle after the control write. Record order and field placement are compared word by word when each record is drained.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;
  localparam int HS_W = 6;
  localparam int DS_W = 8;

  typedef struct packed {
    logic [1:0]      chan;
    logic [HS_W-1:0] hstat;
    logic [DS_W-1:0] dstat;
  } cq_entry_t;

  // high word: empty, valid, channel tag, host code
  function automatic logic [31:0] hi_word(input logic empty, input cq_entry_t e);
    logic [31:0] w;
    w = '0;
    w[31] = empty;
    w[30] = ~empty;
    if (!empty) begin
      w[9:8] = e.chan;
      w[5:0] = e.hstat;
    end
    return w;
  endfunction

  // low word: drive status byte only
  function automatic logic [31:0] lo_word(input logic empty, input cq_entry_t e);
    logic [31:0] w;
    w = '0;
    if (!empty) w[23:16] = e.dstat;
    return w;
  endfunction
endpackage

// File: rtl/cq_rr_arb.sv
`timescale 1ns/1ps
module cq_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx,
  output logic                 gnt_any
);
  localparam int IW = $clog2(N);

  logic [IW-1:0] start_q;

  function automatic logic [IW-1:0] rot(input logic [IW-1:0] base, input int k);
    int s;
    s = int'(base) + k;
    if (s >= N) s = s - N;
    return IW'(s);
  endfunction

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (en && !gnt_any && req[rot(start_q, k)]) begin
        gnt[rot(start_q, k)] = 1'b1;
        gnt_idx              = rot(start_q, k);
        gnt_any              = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       start_q <= '0;
    else if (gnt_any) start_q <= rot(gnt_idx, 1);
  end
endmodule

// File: rtl/cq_store.sv
`timescale 1ns/1ps
module cq_store
  import cq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  cq_entry_t                din,
  input  logic                     pop,
  output cq_entry_t                head,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  cq_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign count = cnt_q;
  assign head  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/cq_regs.sv
`timescale 1ns/1ps
module cq_regs
  import cq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  input  logic        rd_sel,
  input  cq_entry_t   head,
  input  logic        empty,
  output logic [31:0] rd_data,
  output logic        irq
);
  logic ien_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (cfg_we) ien_q <= (cfg_wdata != 8'd0);
  end

  assign rd_data = rd_sel ? hi_word(empty, head) : lo_word(empty, head);
  assign irq     = ien_q & ~empty;
endmodule

// File: rtl/cmpl_status_queue.sv
`timescale 1ns/1ps
module cmpl_status_queue
  import cq_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       post_valid,
  input  logic [HS_W*NCH-1:0]  post_hstat,
  input  logic [DS_W*NCH-1:0]  post_dstat,
  output logic [NCH-1:0]       post_ready,
  input  logic                 rd_en,
  input  logic                 rd_sel,
  output logic [31:0]          rd_data,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_wdata,
  output logic                 irq
);
  localparam int IW = $clog2(NCH);
  localparam int CW = $clog2(DEPTH+1);

  logic [HS_W-1:0] hs_arr [NCH];
  logic [DS_W-1:0] ds_arr [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_unpack
    assign hs_arr[c] = post_hstat[c*HS_W +: HS_W];
    assign ds_arr[c] = post_dstat[c*DS_W +: DS_W];
  end

  // named internal events for the checker
  logic          q_empty, q_full;
  logic [CW-1:0] q_count;
  logic          push_evt, pop_evt;
  logic [IW-1:0] gnt_idx;
  cq_entry_t     new_ent, head_ent;

  cq_rr_arb #(.N(NCH)) u_arb (
    .clk(clk), .rst_n(rst_n), .en(~q_full), .req(post_valid),
    .gnt(post_ready), .gnt_idx(gnt_idx), .gnt_any(push_evt)
  );

  always_comb begin
    new_ent       = '0;
    new_ent.chan  = 2'(gnt_idx);
    new_ent.hstat = hs_arr[gnt_idx];
    new_ent.dstat = ds_arr[gnt_idx];
  end

  assign pop_evt = rd_en & rd_sel & ~q_empty;

  cq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_evt), .din(new_ent),
    .pop(pop_evt), .head(head_ent), .empty(q_empty), .full(q_full),
    .count(q_count)
  );

  cq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_sel(rd_sel), .head(head_ent), .empty(q_empty),
    .rd_data(rd_data), .irq(irq)
  );
endmodule

// File: rtl/cmpl_status_queue_chk.sv
`timescale 1ns/1ps
module cmpl_status_queue_chk #(
  parameter int NCH = 4,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] post_valid,
  input logic [NCH-1:0] post_ready,
  input logic           rd_en,
  input logic           rd_sel,
  input logic [31:0]    rd_data,
  input logic           irq,
  input logic           q_empty,
  input logic           q_full,
  input logic [CW-1:0]  q_count,
  input logic           push_evt,
  input logic           pop_evt
);
  // R6
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(post_ready));

  // R6
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_ready & ~post_valid) == '0);

  // R8
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (post_ready == '0));

  // R4
  count_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !pop_evt) |=> (q_count == $past(q_count) + 1'b1));

  // R4
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !push_evt) |=> (q_count == $past(q_count) - 1'b1));

  // R5
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && q_empty) |-> (rd_data == 32'h8000_0000));

  // R5
  empty_read_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && q_empty && post_ready == '0) |=> q_empty);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty |-> !irq);
endmodule

bind cmpl_status_queue cmpl_status_queue_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_ready(post_ready),
  .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq),
  .q_empty(q_empty), .q_full(q_full), .q_count(q_count),
  .push_evt(push_evt), .pop_evt(pop_evt)
);

// File: tb/cmpl_status_queue_test.sv
`timescale 1ns/1ps
module cmpl_status_queue_test;
  localparam int NCH = 4;
  localparam int DEPTH = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   post_valid = '0;
  logic [6*NCH-1:0] post_hstat = '0;
  logic [8*NCH-1:0] post_dstat = '0;
  logic [NCH-1:0]   post_ready;
  logic             rd_en = 1'b0;
  logic             rd_sel = 1'b0;
  logic [31:0]      rd_data;
  logic             cfg_we = 1'b0;
  logic [7:0]       cfg_wdata = '0;
  logic             irq;

  int total = 0;
  int bad = 0;
  int rr_next = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cmpl_status_queue #(.NCH(NCH), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_hstat(post_hstat),
    .post_dstat(post_dstat), .post_ready(post_ready), .rd_en(rd_en),
    .rd_sel(rd_sel), .rd_data(rd_data), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hi_exp(input int ch, input int hs);
    return 32'h4000_0000 | (32'(ch) << 8) | 32'(hs);
  endfunction

  task automatic set_chan(input int ch, input int hs, input int ds);
    post_hstat[ch*6 +: 6] = 6'(hs);
    post_dstat[ch*8 +: 8] = 8'(ds);
  endtask

  // each task starts and ends at a falling edge with inputs idle
  task automatic read_word(input logic upper, output logic [31:0] v);
    rd_en = 1'b1; rd_sel = upper;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0; rd_sel = 1'b0;
  endtask

  task automatic post_one(input int ch, input int hs, input int ds, input string req);
    set_chan(ch, hs, ds);
    post_valid[ch] = 1'b1;
    #1 check(req, 32'(post_ready), 32'(1) << ch);
    @(negedge clk);
    post_valid = '0;
    rr_next = (ch + 1) % NCH;
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 irq", 32'(irq), 32'd0);
    read_word(1'b0, v); check("R1 low", v, 32'd0);
    read_word(1'b1, v); check("R1 high", v, 32'h8000_0000);
    cfg_write(8'd0);
    set_chan(0, 1, 1); #1 check("R1 enable clear", 32'(irq), 0);
  endtask

  task automatic t_single;
    logic [31:0] v;
    cfg_write(8'd1);
    post_one(2, 3, 8'h51, "R6 single grant");
    check("R9 irq rises", 32'(irq), 32'd1);
    read_word(1'b0, v); check("R3 low word", v, 32'h0051_0000);
    read_word(1'b0, v); check("R3 low no pop", v, 32'h0051_0000);
    read_word(1'b1, v); check("R2 high word", v, hi_exp(2, 3));
    check("R9 irq falls", 32'(irq), 32'd0);
    read_word(1'b1, v); check("R4 popped", v, 32'h8000_0000);
  endtask

  task automatic t_empty_read;
    logic [31:0] v;
    read_word(1'b1, v); check("R5 empty high", v, 32'h8000_0000);
    read_word(1'b1, v); check("R5 empty again", v, 32'h8000_0000);
    check("R5 no irq", 32'(irq), 32'd0);
    post_one(0, 6'h2a, 8'hc3, "R6 grant ch0");
    read_word(1'b0, v); check("R5 next low", v, 32'h00c3_0000);
    read_word(1'b1, v); check("R5 next high", v, hi_exp(0, 6'h2a));
  endtask

  task automatic t_rr;
    logic [31:0] v;
    int order [NCH];
    for (int c = 0; c < NCH; c++) begin
      set_chan(c, 10 + c, 8'ha0 + c);
    end
    post_valid = '1;
    for (int n = 0; n < NCH; n++) begin
      int exp_ch;
      exp_ch = -1;
      for (int k = 0; k < NCH; k++) begin
        if (exp_ch < 0 && post_valid[(rr_next + k) % NCH]) exp_ch = (rr_next + k) % NCH;
      end
      #1 check("R6 rotation", 32'(post_ready), 32'(1) << exp_ch);
      order[n] = exp_ch;
      @(negedge clk);
      post_valid[exp_ch] = 1'b0;
      rr_next = (exp_ch + 1) % NCH;
    end
    for (int n = 0; n < NCH; n++) begin
      read_word(1'b0, v); check("R7 held data", v, 32'(8'ha0 + order[n]) << 16);
      read_word(1'b1, v); check("R7 held tag", v, hi_exp(order[n], 10 + order[n]));
    end
  endtask

  task automatic t_full;
    logic [31:0] v;
    for (int k = 0; k < DEPTH; k++) post_one(1, k, k, "R8 fill");
    set_chan(1, 9, 8'h99);
    post_valid[1] = 1'b1;
    #1 check("R8 stall at full", 32'(post_ready), 32'd0);
    rd_en = 1'b1; rd_sel = 1'b1;
    #1 check("R8 head while full", rd_data, hi_exp(1, 0));
    check("R8 still stalled", 32'(post_ready), 32'd0);
    @(negedge clk);
    rd_en = 1'b0; rd_sel = 1'b0;
    #1 check("R8 resumes", 32'(post_ready), 32'd2);
    @(negedge clk);
    post_valid = '0;
    rr_next = 2;
    // R10: enable toggling while records are held
    cfg_write(8'd0);
    check("R10 disable", 32'(irq), 32'd0);
    cfg_write(8'h40);
    check("R10 enable nonzero", 32'(irq), 32'd1);
    for (int k = 1; k < DEPTH; k++) begin
      read_word(1'b1, v); check("R4 order", v, hi_exp(1, k));
    end
    read_word(1'b0, v); check("R8 no drop low", v, 32'h0099_0000);
    read_word(1'b1, v); check("R8 no drop high", v, hi_exp(1, 9));
    read_word(1'b1, v); check("R4 drained", v, 32'h8000_0000);
    check("R9 irq low empty", 32'(irq), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_empty_read();
    t_rr();
    t_full();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule